// File: doc/BRIEF.md
# Delay-Line Phase Switch Sequencer

This block moves the sampling clock of a programmable delay line to a new output phase without producing a glitch on that clock. A 4-bit phase index is presented along with a one-cycle start pulse. The sequencer holds a local image of the delay line's 32-bit configuration word and updates it in four read-modify-write steps, raising a one-cycle write strobe each time the image changes. Between steps it polls a feedback bit that reports whether the delay line's clock output is enabled.

The steps run in a fixed order:
1. Disable the clock output and clock-data recovery, and select the external phase source.
2. Wait for the clock output to report off.
3. Write the Gray-coded phase.
4. Re-enable the clock output and wait for it to report on.
5. Hand control back to clock-data recovery.

Each wait is bounded by a cycle count. If the feedback never reaches the expected level, the run stops with a sticky error. The feedback passes through a configurable synchronizer before it is used.

Top module: `dll_phase_seq`

## Requirements
- R1: After reset the image on `cfg_o` equals the `CFG_INIT` parameter, and `busy_o`, `wr_o`, `done_o` and `err_o` are all 0.
- R2: The first write of a run clears bit 17 (recovery enable) and bit 18 (clock-output enable), and sets bit 19 (external phase select) and bit 16 (delay-line enable). All other bits are left unchanged. Every write sets `wr_o` for exactly one cycle.
- R3: The second write happens only after the synchronized feedback reads 0. It changes only the select field, bits 23:20.
- R4: The select field holds the Gray code of the phase index. Indices 0 to 15 map to 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8 (hex), which is index XOR (index >> 1).
- R5: The third write sets bit 18 and changes nothing else. The sequencer then waits for the synchronized feedback to read 1.
- R6: The fourth write sets bit 17 and clears bit 19 in the same update. `done_o` pulses for one cycle with that write, and a successful run makes exactly four writes.
- R7: If the feedback stays at the wrong level, `err_o` rises `POLL_CYCLES` cycles after the write that began the wait. No further write follows, and the block returns to idle.
- R8: `err_o` stays at 1 until the next accepted start, and it clears on the edge that accepts that start.
- R9: A start pulse that arrives while `busy_o` is 1 is ignored. The phase being programmed is not changed and no extra run follows.
- R10: While idle with no start, `cfg_o` does not change and `wr_o` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to program a new phase |
| phase_i | input | PHASE_W | Phase index, captured when start is accepted |
| ck_out_fb_i | input | 1 | Clock-output-enable feedback from the delay line |
| cfg_o | output | CFG_W | Configuration word image |
| wr_o | output | 1 | Pulses when `cfg_o` has been updated |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run completes |
| err_o | output | 1 | Sticky poll-timeout flag |

## Verification
The hardest situations to reach are the two timeouts, because the delay line normally answers. The bench models the feedback as either a copy of bit 18 of `cfg_o` with a selectable delay, or a signal stuck at 1 or stuck at 0. The stuck-at-1 mode traps the first wait and the stuck-at-0 mode traps the second, and in each case the bench counts the exact cycle on which the error rises. A start pulse is also driven in the middle of a slow run, with the feedback delayed, to show that a request made while busy is dropped.

// File: rtl/dll_phase_pkg.sv
package dll_phase_pkg;

   typedef enum logic [2:0] {
      SEQ_IDLE      = 3'd0,
      SEQ_QUIESCE   = 3'd1,
      SEQ_WAIT_LOW  = 3'd2,
      SEQ_SET_SEL   = 3'd3,
      SEQ_CLK_ON    = 3'd4,
      SEQ_WAIT_HIGH = 3'd5,
      SEQ_HANDOVER  = 3'd6
   } seq_state_e;

endpackage

// File: rtl/dll_gray_enc.sv
module dll_gray_enc #(
   parameter int W = 4
) (
   input  logic [W-1:0] bin_i,
   output logic [W-1:0] gray_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("dll_gray_enc: W must be at least 1");
      end
   endgenerate

   assign gray_o[W-1] = bin_i[W-1];

   generate
      for (genvar b = 0; b < W - 1; b++) begin : g_bit
         assign gray_o[b] = bin_i[b] ^ bin_i[b+1];
      end
   endgenerate

endmodule

// File: rtl/dll_fb_sync.sv
module dll_fb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("dll_fb_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] pipe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= {pipe_q[STAGES-1:0] << 1} | {{(STAGES-1){1'b0}}, d_i};
         end
         assign q_o = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/dll_poll_timer.sv
module dll_poll_timer #(
   parameter int LIMIT = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic run_i,
   output logic expired_o
);

   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("dll_poll_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (clear_i)            cnt_q <= '0;
      else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/dll_phase_seq.sv
module dll_phase_seq
   import dll_phase_pkg::*;
#(
   parameter int CFG_W       = 32,
   parameter int PHASE_W     = 4,
   parameter int SEL_LSB     = 20,
   parameter int DLL_EN_BIT  = 16,
   parameter int CDR_EN_BIT  = 17,
   parameter int CK_OUT_BIT  = 18,
   parameter int CDR_EXT_BIT = 19,
   parameter int POLL_CYCLES = 5000,
   parameter int SYNC_STAGES = 2,
   parameter logic [CFG_W-1:0] CFG_INIT = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [PHASE_W-1:0] phase_i,
   input  logic               ck_out_fb_i,
   output logic [CFG_W-1:0]   cfg_o,
   output logic               wr_o,
   output logic               busy_o,
   output logic               done_o,
   output logic               err_o
);

   localparam logic [CFG_W-1:0] ONE      = CFG_W'(1);
   localparam logic [CFG_W-1:0] M_DLL    = ONE << DLL_EN_BIT;
   localparam logic [CFG_W-1:0] M_CDR    = ONE << CDR_EN_BIT;
   localparam logic [CFG_W-1:0] M_CKOUT  = ONE << CK_OUT_BIT;
   localparam logic [CFG_W-1:0] M_EXT    = ONE << CDR_EXT_BIT;
   localparam logic [CFG_W-1:0] M_SEL    = ((ONE << PHASE_W) - ONE) << SEL_LSB;

   generate
      if (SEL_LSB + PHASE_W > CFG_W) begin : g_bad_sel
         $error("dll_phase_seq: select field exceeds configuration width");
      end
      if (DLL_EN_BIT >= CFG_W || CDR_EN_BIT >= CFG_W ||
          CK_OUT_BIT >= CFG_W || CDR_EXT_BIT >= CFG_W) begin : g_bad_bit
         $error("dll_phase_seq: control bit outside configuration width");
      end
   endgenerate

   seq_state_e         state_q;
   logic [CFG_W-1:0]   cfg_q;
   logic [PHASE_W-1:0] phase_q;
   logic [PHASE_W-1:0] gray_w;
   logic               wr_q, done_q, err_q;
   logic               fb_s;
   logic               tmr_clear, tmr_run, tmr_expired;

   dll_gray_enc #(.W(PHASE_W)) gray_i (
      .bin_i (phase_q),
      .gray_o(gray_w)
   );

   dll_fb_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (ck_out_fb_i),
      .q_o  (fb_s)
   );

   assign tmr_clear = (state_q == SEQ_QUIESCE) || (state_q == SEQ_CLK_ON);
   assign tmr_run   = (state_q == SEQ_WAIT_LOW) || (state_q == SEQ_WAIT_HIGH);

   dll_poll_timer #(.LIMIT(POLL_CYCLES)) tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (tmr_clear),
      .run_i    (tmr_run),
      .expired_o(tmr_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cfg_q   <= CFG_INIT;
         phase_q <= '0;
         wr_q    <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         wr_q   <= 1'b0;
         done_q <= 1'b0;
         case (state_q)
            SEQ_IDLE: begin
               if (start_i) begin
                  phase_q <= phase_i;
                  err_q   <= 1'b0;
                  state_q <= SEQ_QUIESCE;
               end
            end
            SEQ_QUIESCE: begin
               cfg_q   <= (cfg_q & ~(M_CDR | M_CKOUT)) | M_EXT | M_DLL;
               wr_q    <= 1'b1;
               state_q <= SEQ_WAIT_LOW;
            end
            SEQ_WAIT_LOW: begin
               if (!fb_s) begin
                  state_q <= SEQ_SET_SEL;
               end else if (tmr_expired) begin
                  err_q   <= 1'b1;
                  state_q <= SEQ_IDLE;
               end
            end
            SEQ_SET_SEL: begin
               cfg_q   <= (cfg_q & ~M_SEL) | (CFG_W'(gray_w) << SEL_LSB);
               wr_q    <= 1'b1;
               state_q <= SEQ_CLK_ON;
            end
            SEQ_CLK_ON: begin
               cfg_q   <= cfg_q | M_CKOUT;
               wr_q    <= 1'b1;
               state_q <= SEQ_WAIT_HIGH;
            end
            SEQ_WAIT_HIGH: begin
               if (fb_s) begin
                  state_q <= SEQ_HANDOVER;
               end else if (tmr_expired) begin
                  err_q   <= 1'b1;
                  state_q <= SEQ_IDLE;
               end
            end
            SEQ_HANDOVER: begin
               cfg_q   <= (cfg_q | M_CDR) & ~M_EXT;
               wr_q    <= 1'b1;
               done_q  <= 1'b1;
               state_q <= SEQ_IDLE;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign cfg_o  = cfg_q;
   assign wr_o   = wr_q;
   assign done_o = done_q;
   assign err_o  = err_q;
   assign busy_o = (state_q != SEQ_IDLE);

endmodule

// File: rtl/dll_phase_seq_chk.sv
module dll_phase_seq_chk #(
   parameter int CFG_W       = 32,
   parameter int PHASE_W     = 4,
   parameter int DLL_EN_BIT  = 16,
   parameter int CDR_EN_BIT  = 17,
   parameter int CK_OUT_BIT  = 18,
   parameter int CDR_EXT_BIT = 19
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic               busy_o,
   input logic               wr_o,
   input logic               done_o,
   input logic               err_o,
   input logic [CFG_W-1:0]   cfg_o,
   input logic [PHASE_W-1:0] phase_q
);

   // R2: the delay-line enable is set by the first write and never dropped
   assert_wr_dll_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |-> cfg_o[DLL_EN_BIT]);

   assert_done_final_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cfg_o[CDR_EN_BIT] && cfg_o[CK_OUT_BIT] && !cfg_o[CDR_EXT_BIT] && !busy_o));

   assert_done_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   assert_err_no_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !busy_o) |-> !wr_o);

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !start_i) |=> err_o);

   assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(phase_q));

   assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(cfg_o) && !wr_o));

endmodule

bind dll_phase_seq dll_phase_seq_chk #(
   .CFG_W      (CFG_W),
   .PHASE_W    (PHASE_W),
   .DLL_EN_BIT (DLL_EN_BIT),
   .CDR_EN_BIT (CDR_EN_BIT),
   .CK_OUT_BIT (CK_OUT_BIT),
   .CDR_EXT_BIT(CDR_EXT_BIT)
) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .busy_o (busy_o),
   .wr_o   (wr_o),
   .done_o (done_o),
   .err_o  (err_o),
   .cfg_o  (cfg_o),
   .phase_q(phase_q)
);

// File: tb/dll_phase_seq_tb_top.sv
module dll_phase_seq_tb_top;

   localparam int          N    = 24;
   localparam logic [31:0] INIT = 32'hC30E_5A5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [3:0]  phase_i = '0;
   logic        ck_fb;
   logic [31:0] cfg_o;
   logic        wr_o, busy_o, done_o, err_o;

   always #5 clk = ~clk;

   dll_phase_seq #(.POLL_CYCLES(N), .CFG_INIT(INIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_i(phase_i),
      .ck_out_fb_i(ck_fb), .cfg_o(cfg_o), .wr_o(wr_o), .busy_o(busy_o),
      .done_o(done_o), .err_o(err_o)
   );

   // feedback model: 0 follow bit 18 with delay, 1 stuck high, 2 stuck low
   int          fb_mode = 0;
   int          fb_dly  = 0;
   logic [15:0] fb_pipe = '0;
   always @(negedge clk) fb_pipe <= {fb_pipe[14:0], cfg_o[18]};
   assign ck_fb = (fb_mode == 1) ? 1'b1 :
                  (fb_mode == 2) ? 1'b0 :
                  (fb_dly == 0)  ? cfg_o[18] : fb_pipe[fb_dly-1];

   logic [31:0] wlog [8];
   int          wcnt = 0;
   always @(negedge clk) if (wr_o) begin
      if (wcnt < 8) wlog[wcnt] <= cfg_o;
      wcnt <= wcnt + 1;
   end

   int tests = 0, fails = 0;
   logic [31:0] img;
   logic [3:0] gtab [16] = '{4'h0,4'h1,4'h3,4'h2,4'h6,4'h7,4'h5,4'h4,
                            4'hC,4'hD,4'hF,4'hE,4'hA,4'hB,4'h9,4'h8};

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] w1(input logic [31:0] x); return (x & ~32'h0006_0000) | 32'h0009_0000; endfunction
   function automatic logic [31:0] w2(input logic [31:0] x, input logic [3:0] p); return (x & ~32'h00F0_0000) | ({28'd0, gtab[p]} << 20); endfunction
   function automatic logic [31:0] w3(input logic [31:0] x); return x | 32'h0004_0000; endfunction
   function automatic logic [31:0] w4(input logic [31:0] x); return (x | 32'h0002_0000) & ~32'h0008_0000; endfunction

   task automatic pulse_start(input logic [3:0] p);
      @(negedge clk); phase_i = p; start_i = 1'b1;
      @(posedge clk); @(negedge clk); start_i = 1'b0;
   endtask

   task automatic wait_end(output bit got_done, output bit got_err);
      got_done = 0; got_err = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (done_o) got_done = 1;
         if (!busy_o) begin got_err = err_o; break; end
      end
   endtask

   task automatic t_reset;
      chk(cfg_o == INIT, "R1 image", cfg_o, INIT);
      chk({busy_o, wr_o, done_o, err_o} == 4'b0, "R1 flags", {28'd0, busy_o, wr_o, done_o, err_o}, 0);
      repeat (5) @(negedge clk);
      chk(cfg_o == INIT && wcnt == 0, "R10 idle", cfg_o, INIT);
   endtask

   task automatic t_run(input logic [3:0] p, input int dly);
      bit d, e;
      logic [31:0] e1, e2, e3, e4;
      fb_mode = 0; fb_dly = dly; wcnt = 0;
      pulse_start(p);
      wait_end(d, e);
      @(negedge clk);
      e1 = w1(img); e2 = w2(e1, p); e3 = w3(e2); e4 = w4(e3);
      chk(d && !e, "R6 done", {30'd0, d, e}, 32'd2);
      chk(wcnt == 4, "R6 write count", wcnt, 4);
      chk(wlog[0] == e1, "R2 first write", wlog[0], e1);
      chk(wlog[1] == e2, "R3 R4 select write", wlog[1], e2);
      chk(wlog[2] == e3, "R5 clock on write", wlog[2], e3);
      chk(wlog[3] == e4, "R6 handover write", wlog[3], e4);
      img = e4;
   endtask

   task automatic t_all_phases;
      for (int p = 0; p < 16; p++) t_run(4'(p), p % 6);
      t_run(4'd9, 12);
   endtask

   task automatic t_timeout_low;
      logic [31:0] e1;
      fb_mode = 1; wcnt = 0;
      e1 = w1(img);
      pulse_start(4'd3);
      @(posedge clk); @(negedge clk);
      chk(wr_o == 1'b1, "R2 first strobe", wr_o, 1);
      repeat (N - 1) @(posedge clk);
      @(negedge clk);
      chk(err_o == 1'b0, "R7 no early error", err_o, 0);
      @(posedge clk); @(negedge clk);
      chk(err_o == 1'b1 && !busy_o, "R7 error on time", {busy_o, err_o}, 1);
      repeat (5) @(negedge clk);
      chk(wcnt == 1, "R7 no write after timeout", wcnt, 1);
      chk(cfg_o == e1, "R7 image after timeout", cfg_o, e1);
      img = e1;
   endtask

   task automatic t_err_sticky;
      repeat (20) @(negedge clk);
      chk(err_o == 1'b1, "R8 error held", err_o, 1);
      chk(cfg_o == img && wcnt == 1, "R10 idle after error", cfg_o, img);
      fb_mode = 0; fb_dly = 2;
      pulse_start(4'd6);
      chk(err_o == 1'b0 && busy_o, "R8 error cleared by start", {busy_o, err_o}, 2);
      wcnt = 0;
      begin
         bit d, e;
         logic [31:0] ex;
         wait_end(d, e);
         @(negedge clk);
         ex = w4(w3(w2(w1(img), 4'd6)));
         chk(d && cfg_o == ex, "R8 run after error", cfg_o, ex);
         img = ex;
      end
   endtask

   task automatic t_timeout_high;
      bit d, e;
      logic [31:0] ex;
      fb_mode = 2; wcnt = 0;
      pulse_start(4'd11);
      wait_end(d, e);
      repeat (4) @(negedge clk);
      ex = w3(w2(w1(img), 4'd11));
      chk(e && !d, "R7 second wait timeout", {30'd0, d, e}, 1);
      chk(wcnt == 3 && cfg_o == ex, "R7 image after second timeout", cfg_o, ex);
      img = ex;
   endtask

   task automatic t_busy_ignore;
      bit d, e;
      logic [31:0] ex;
      fb_mode = 0; fb_dly = 8; wcnt = 0;
      pulse_start(4'd5);
      repeat (2) @(negedge clk);
      phase_i = 4'd10; start_i = 1'b1;
      repeat (3) @(negedge clk);
      start_i = 1'b0;
      wait_end(d, e);
      repeat (10) @(negedge clk);
      ex = w4(w3(w2(w1(img), 4'd5)));
      chk(cfg_o == ex, "R9 phase kept", cfg_o, ex);
      chk(wcnt == 4 && !busy_o, "R9 no extra run", wcnt, 4);
      img = ex;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++; tests++;
         $display("FAIL watchdog R6 act=%0d exp=%0d", cyc, 100000);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      img = INIT;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_all_phases();
      t_timeout_low();
      t_err_sticky();
      t_timeout_high();
      t_busy_ignore();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule